// File: doc/BRIEF.md
# Serial NOR Flash Quad-Enable and Bulk-Erase Sequencer

This block is a hardware state machine. It runs two maintenance operations on a serial NOR flash with no processor involved. A one-cycle start pulse, with an operation select, launches one of them.

- **Quad enable** sets the quad-I/O bit in the flash configuration register.
- **Bulk erase** wipes the whole array.

Each operation is a chain of short chip-select-framed SPI transactions. The block reads the registers, sends write-enable, writes the registers or the erase command, and then polls the busy flag. The poll has a bounded count.

Before it acts, the block reads the configuration register and rejects any part whose latency field is not zero. A quad request on a part that already has the quad bit set completes at once. After a register write, the configuration register is read back to confirm the quad bit. The result is a one-cycle completion pulse and an error flag that stays set until the next start. The block also presents the last status and configuration bytes it read.

The serial side is a mode-3 byte shifter: the clock idles high, data is sampled on the rising edge and bytes go out MSB first. The clock rate comes from a half-period divider parameter.

Top module: `flash_cfg_seq`

## Requirements
- R1: After reset, cs_no and sclk_o are high and busy_o, done_o and error_o are low.
- R2: Each transaction holds cs_no low for its whole length. Between transactions cs_no is high for at least GAP_CYC clocks. sclk_o idles high and mosi_o changes only away from rising sclk_o edges. Bytes are sent MSB first, and miso_i is sampled on rising edges.
- R3: Every operation begins with a configuration read: byte 0x35, then one byte whose returned value is captured. If bits 7:6 of that value are not 00, the operation ends with an error and sends no further transaction.
- R4: With op_i = 0 (quad enable), a configuration value with bit 1 set ends the operation without error after that single read.
- R5: With op_i = 0 and bit 1 clear, the block sends three transactions in this order. First a status read: 0x05 plus one returned byte. Then write-enable: the single byte 0x06. Then a 3-byte register write: 0x01, the status byte just read, and the configuration byte with bit 1 set.
- R6: After a register write or an erase command, status reads (0x05) repeat while bit 0 of the returned value is 1, up to MAX_POLLS reads. If all MAX_POLLS reads show bit 0 set, the operation ends with an error.
- R7: In quad enable, once the busy bit clears, the configuration register is read again. The operation ends with an error if bit 1 is clear in that value, and without error if it is set.
- R8: With op_i = 1 (bulk erase) and a zero latency field, the block sends write-enable (0x06), then the single byte 0x60, then runs the poll of R6. It ends without error when the busy bit clears.
- R9: status_o and config_o hold the last status byte and the last configuration byte read.
- R10: A start_i pulse while busy_o is high is ignored. The running operation's transaction sequence is unchanged and it completes once.
- R11: done_o is a one-cycle pulse at completion. error_o is valid with it and stays unchanged until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| op_i | input | 1 | Operation: 0 quad enable, 1 bulk erase |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Result of the last operation, held until next start |
| status_o | output | 8 | Last status register byte read |
| config_o | output | 8 | Last configuration register byte read |
| sclk_o | output | 1 | Serial clock, idle high |
| cs_no | output | 1 | Flash chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
The bench contains a behavioural flash that decodes every transaction from the serial pins. Each operation's sequence of opcodes and byte counts is compared with a list derived from the requirements.

Quad enable is run against several kinds of configuration value:
- every non-zero latency code, which must stop after one read;
- all sixteen filler patterns with the quad bit already set, which must stop cleanly;
- several patterns with the quad bit clear, which must write the right bytes.

Busy counts are swept from zero to beyond MAX_POLLS for both operations. This separates a clean finish on the last permitted poll from a timeout. A flash that refuses the write tells apart the read-back check from the poll result. A start pulse in mid-operation and a clean run after a failed one exercise the ignore rule and the clearing of the error flag.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int unsigned FRAME_MAX = 3;
  localparam int unsigned LEN_W     = 2;

  localparam logic [7:0] OPC_RD_CFG    = 8'h35;
  localparam logic [7:0] OPC_RD_STS    = 8'h05;
  localparam logic [7:0] OPC_WR_EN     = 8'h06;
  localparam logic [7:0] OPC_WR_REG    = 8'h01;
  localparam logic [7:0] OPC_ERASE_ALL = 8'h60;

  localparam int unsigned CFG_QUAD_BIT = 1;
  localparam int unsigned STS_BUSY_BIT = 0;

  typedef logic [FRAME_MAX-1:0][7:0] frame_t;

  typedef enum logic [1:0] {FR_IDLE, FR_LEAD, FR_XFER, FR_GAP} fr_state_e;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_RD_CFG, SQ_RD_STS, SQ_WR_EN,
    SQ_WR_REG, SQ_ERASE, SQ_POLL, SQ_VERIFY
  } sq_state_e;

  typedef enum logic {OP_QUAD = 1'b0, OP_ERASE = 1'b1} op_e;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);

  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [3:0]       bit_q;
  logic [7:0]       tx_q, rx_q;
  logic             sclk_q, busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          tx_q   <= tx_i;
          div_q  <= '0;
          bit_q  <= '0;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (sclk_q) begin
          // falling edge: next bit goes out, first bit is already on the line
          sclk_q <= 1'b0;
          if (bit_q != 4'd0) tx_q <= {tx_q[6:0], 1'b0};
        end else begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
          bit_q  <= bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import flash_seq_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned GAP_CYC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  frame_t           tx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rx_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);

  localparam int unsigned GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

  fr_state_e        state_q;
  frame_t           tx_q;
  logic [LEN_W-1:0] len_q, idx_q;
  logic [GAP_W-1:0] gap_q;
  logic [7:0]       rx_q;
  logic             cs_q, done_q;

  logic       sh_start, sh_busy, sh_done;
  logic [7:0] sh_rx;

  assign sh_start = (state_q == FR_LEAD);

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .tx_i    (tx_q[idx_q]),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .rx_o    (sh_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      tx_q    <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
      rx_q    <= '0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        FR_IDLE: if (start_i) begin
          tx_q    <= tx_i;
          len_q   <= len_i;
          idx_q   <= '0;
          cs_q    <= 1'b0;
          state_q <= FR_LEAD;
        end
        FR_LEAD: state_q <= FR_XFER;
        FR_XFER: if (sh_done && !sh_busy) begin
          rx_q <= sh_rx;
          if (idx_q == len_q - 1'b1) begin
            cs_q    <= 1'b1;
            gap_q   <= '0;
            state_q <= FR_GAP;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= FR_LEAD;
          end
        end
        FR_GAP: begin
          if (gap_q == GAP_LAST) begin
            done_q  <= 1'b1;
            state_q <= FR_IDLE;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != FR_IDLE);
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign cs_no  = cs_q;

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned MAX_POLLS = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             op_i,
  output logic             fr_start_o,
  output logic [LEN_W-1:0] fr_len_o,
  output frame_t           fr_tx_o,
  input  logic             fr_done_i,
  input  logic [7:0]       fr_rx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic [7:0]       status_o,
  output logic [7:0]       config_o
);

  localparam int unsigned PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  sq_state_e     state_q;
  op_e           op_q;
  logic          pend_q, fr_start_q, done_q, err_q;
  logic [7:0]    sts_q, cfg_q;
  logic [PW-1:0] poll_q;

  // frame contents follow the state; the engine latches them at its start
  always_comb begin
    fr_len_o = '0;
    fr_tx_o  = '0;
    case (state_q)
      SQ_RD_CFG, SQ_VERIFY: begin fr_len_o = 2'd2; fr_tx_o[0] = OPC_RD_CFG; end
      SQ_RD_STS, SQ_POLL:   begin fr_len_o = 2'd2; fr_tx_o[0] = OPC_RD_STS; end
      SQ_WR_EN:             begin fr_len_o = 2'd1; fr_tx_o[0] = OPC_WR_EN; end
      SQ_ERASE:             begin fr_len_o = 2'd1; fr_tx_o[0] = OPC_ERASE_ALL; end
      SQ_WR_REG: begin
        fr_len_o   = 2'd3;
        fr_tx_o[0] = OPC_WR_REG;
        fr_tx_o[1] = sts_q;
        fr_tx_o[2] = cfg_q | (8'd1 << CFG_QUAD_BIT);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      op_q       <= OP_QUAD;
      pend_q     <= 1'b0;
      fr_start_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      sts_q      <= '0;
      cfg_q      <= '0;
      poll_q     <= '0;
    end else begin
      done_q     <= 1'b0;
      fr_start_q <= 1'b0;
      if (state_q == SQ_IDLE) begin
        if (start_i) begin
          op_q    <= op_e'(op_i);
          err_q   <= 1'b0;
          pend_q  <= 1'b0;
          state_q <= SQ_RD_CFG;
        end
      end else if (!pend_q) begin
        fr_start_q <= 1'b1;
        pend_q     <= 1'b1;
      end else if (fr_done_i) begin
        pend_q <= 1'b0;
        case (state_q)
          SQ_RD_CFG: begin
            cfg_q <= fr_rx_i;
            if (fr_rx_i[7:6] != 2'b00) begin
              state_q <= SQ_IDLE; done_q <= 1'b1; err_q <= 1'b1;
            end else if (op_q == OP_ERASE) begin
              state_q <= SQ_WR_EN;
            end else if (fr_rx_i[CFG_QUAD_BIT]) begin
              state_q <= SQ_IDLE; done_q <= 1'b1; err_q <= 1'b0;
            end else begin
              state_q <= SQ_RD_STS;
            end
          end
          SQ_RD_STS: begin
            sts_q   <= fr_rx_i;
            state_q <= SQ_WR_EN;
          end
          SQ_WR_EN: state_q <= (op_q == OP_ERASE) ? SQ_ERASE : SQ_WR_REG;
          SQ_WR_REG, SQ_ERASE: begin
            poll_q  <= '0;
            state_q <= SQ_POLL;
          end
          SQ_POLL: begin
            sts_q <= fr_rx_i;
            if (!fr_rx_i[STS_BUSY_BIT]) begin
              if (op_q == OP_QUAD) begin
                state_q <= SQ_VERIFY;
              end else begin
                state_q <= SQ_IDLE; done_q <= 1'b1; err_q <= 1'b0;
              end
            end else if (poll_q == POLL_LAST) begin
              state_q <= SQ_IDLE; done_q <= 1'b1; err_q <= 1'b1;
            end else begin
              poll_q <= poll_q + 1'b1;
            end
          end
          SQ_VERIFY: begin
            cfg_q   <= fr_rx_i;
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
            err_q   <= ~fr_rx_i[CFG_QUAD_BIT];
          end
          default: state_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign fr_start_o = fr_start_q;
  assign busy_o     = (state_q != SQ_IDLE);
  assign done_o     = done_q;
  assign error_o    = err_q;
  assign status_o   = sts_q;
  assign config_o   = cfg_q;

endmodule

// File: rtl/flash_cfg_seq.sv
module flash_cfg_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned HALF_DIV  = 4,
  parameter int unsigned GAP_CYC   = 2,
  parameter int unsigned MAX_POLLS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       op_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       error_o,
  output logic [7:0] status_o,
  output logic [7:0] config_o,
  output logic       sclk_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i
);

  logic             fr_start, fr_busy, fr_done;
  logic [LEN_W-1:0] fr_len;
  frame_t           fr_tx;
  logic [7:0]       fr_rx;

  flash_op_seq #(.MAX_POLLS(MAX_POLLS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_i       (op_i),
    .fr_start_o (fr_start),
    .fr_len_o   (fr_len),
    .fr_tx_o    (fr_tx),
    .fr_done_i  (fr_done && !fr_busy),
    .fr_rx_i    (fr_rx),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .error_o    (error_o),
    .status_o   (status_o),
    .config_o   (config_o)
  );

  spi_frame_engine #(.HALF_DIV(HALF_DIV), .GAP_CYC(GAP_CYC)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fr_start),
    .len_i   (fr_len),
    .tx_i    (fr_tx),
    .busy_o  (fr_busy),
    .done_o  (fr_done),
    .rx_o    (fr_rx),
    .cs_no   (cs_no),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .miso_i  (miso_i)
  );

endmodule

// File: rtl/flash_cfg_seq_chk.sv
module flash_cfg_seq_chk #(
  parameter int unsigned GAP_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic error_o,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o
);

  logic [7:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= 8'hff;
    else if (!cs_no)    hi_cnt <= '0;
    else if (hi_cnt != 8'hff) hi_cnt <= hi_cnt + 8'd1;
  end

  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);  // R2
  AST_SCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);  // R2
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));  // R2
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= 8'(GAP_CYC)));  // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R11
  AST_ERR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !error_o);  // R11
  AST_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(error_o));  // R11
  AST_BUSY_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));  // R10

endmodule

bind flash_cfg_seq flash_cfg_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .error_o (error_o),
  .cs_no   (cs_no),
  .sclk_o  (sclk_o),
  .mosi_o  (mosi_o)
);

// File: tb/flash_cfg_seq_tb.sv
`timescale 1ns/1ps
module flash_cfg_seq_tb;

  localparam int HALF = 2;
  localparam int GAP  = 2;
  localparam int MP   = 4;
  localparam logic [7:0] STS_BASE = 8'h1c;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op = 1'b0;
  logic busy, done, err, sclk, cs_n, mosi;
  logic miso = 1'b0;
  logic [7:0] sts, cfg;

  int n_chk = 0, n_err = 0, cycles = 0, done_cnt = 0;

  always #2 clk = ~clk;

  flash_cfg_seq #(.HALF_DIV(HALF), .GAP_CYC(GAP), .MAX_POLLS(MP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .busy_o(busy), .done_o(done), .error_o(err), .status_o(sts), .config_o(cfg),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  // behavioural flash
  logic [7:0] m_cr, m_sr, cur;
  logic [7:0] fb [0:3];
  int m_wip_left = 0, m_wip_cfg = 0, rise = 0, log_n = 0;
  bit m_wel = 0, m_stuck = 0, wr_seen = 0;
  logic [7:0] wr_sr, wr_cr;
  logic [7:0] log_op [0:63];
  int log_len [0:63];

  always @(negedge cs_n) begin rise = 0; miso <= 1'b0; end

  always @(posedge sclk) if (!cs_n) begin
    cur = {cur[6:0], mosi};
    rise++;
    if (rise % 8 == 0 && rise <= 32) fb[rise/8-1] = cur;
  end

  always @(negedge sclk) if (!cs_n) begin
    logic [7:0] r;
    r = 8'h00;
    if (rise >= 8) begin
      if (fb[0] == 8'h05) r = {m_sr[7:1], (m_wip_left > 0)};
      else if (fb[0] == 8'h35) r = m_cr;
    end
    miso <= r[7 - rise % 8];
  end

  always @(posedge cs_n) if (rise >= 8) begin
    if (log_n < 64) begin log_op[log_n] = fb[0]; log_len[log_n] = rise / 8; log_n++; end
    case (fb[0])
      8'h06: m_wel = 1;
      8'h01: if (m_wel && rise == 24) begin
        wr_seen = 1; wr_sr = fb[1]; wr_cr = fb[2];
        if (!m_stuck) m_cr = fb[2];
        m_wip_left = m_wip_cfg; m_wel = 0;
      end
      8'h60: if (m_wel) begin m_wip_left = m_wip_cfg; m_wel = 0; end
      8'h05: if (m_wip_left > 0) m_wip_left--;
      default: ;
    endcase
  end

  always @(posedge clk) begin
    cycles++;
    if (done) done_cnt++;
  end

  initial begin
    #(4 * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int opc);
    case (opc)
      8'h06, 8'h60: return 1;
      8'h01: return 3;
      default: return 2;
    endcase
  endfunction

  // runs one operation; poke issues a start with the other op in mid-run (R10)
  task automatic run(input bit o, input logic [7:0] cr0, input int wip, input bit stuck, input bit poke);
    int eo [0:15];
    int en = 0, polls;
    bit eerr = 0, wr = 0, fin = 0;
    logic [7:0] ecfg;
    m_cr = cr0; m_sr = STS_BASE; m_wip_cfg = wip; m_wip_left = 0; m_stuck = stuck;
    m_wel = 0; log_n = 0; wr_seen = 0;
    @(negedge clk); start = 1'b1; op = o;
    @(negedge clk); start = 1'b0;
    chk("R11 error cleared at start", err, 0);
    done_cnt = 0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; op = ~o;
      @(negedge clk); start = 1'b0;
    end
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done) begin fin = 1; break; end
    end
    chk("R11 operation completes", fin, 1);
    // expected transaction list from the requirements
    ecfg = cr0;
    eo[en++] = 8'h35;
    if (cr0[7:6] != 2'b00) eerr = 1;                               // R3
    else if (o == 1'b0 && cr0[1]) eerr = 0;                        // R4
    else begin
      if (o == 1'b0) begin eo[en++] = 8'h05; eo[en++] = 8'h06; eo[en++] = 8'h01; wr = 1; end // R5
      else begin eo[en++] = 8'h06; eo[en++] = 8'h60; end            // R8
      polls = (wip < MP) ? wip + 1 : MP;                            // R6
      for (int p = 0; p < polls; p++) eo[en++] = 8'h05;
      if (wip >= MP) eerr = 1;
      else if (o == 1'b0) begin
        eo[en++] = 8'h35;                                           // R7
        ecfg = stuck ? cr0 : (cr0 | 8'h02);
        eerr = stuck;
      end
      chk("R9 status_o last read", sts, (wip >= MP) ? (STS_BASE | 8'h01) : STS_BASE);
    end
    chk("R3 R6 R8 transaction count", log_n, en);
    for (int i = 0; i < en && i < log_n; i++) begin
      chk("R2 R5 R8 opcode order", log_op[i], eo[i]);
      chk("R2 byte count per frame", log_len[i], exp_len(eo[i]));
    end
    chk("R7 R3 R6 error result", err, eerr);
    chk("R9 config_o last read", cfg, ecfg);
    if (wr) begin
      chk("R5 written status byte", wr_seen ? wr_sr : 8'hxx, STS_BASE);
      chk("R5 written config byte", wr_seen ? wr_cr : 8'hxx, cr0 | 8'h02);
    end
    repeat (8) @(negedge clk);
    chk("R11 single done pulse", done_cnt, 1);
    chk("R11 error held after done", err, eerr);
    chk("R10 idle after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_no reset", cs_n, 1);
    chk("R1 sclk_o reset", sclk, 1);
    chk("R1 busy_o reset", busy, 0);
    chk("R1 done_o reset", done, 0);
    chk("R1 error_o reset", err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", {busy, done, err, cs_n, sclk}, 5'b00011);

    for (int l = 1; l < 4; l++) begin            // R3 latency codes
      run(1'b0, {l[1:0], 6'h00}, 0, 0, 0);
      run(1'b1, {l[1:0], 6'h02}, 0, 0, 0);
    end
    for (int v = 0; v < 16; v++)                 // R4 quad already set
      run(1'b0, {2'b00, v[3:0], 1'b1, v[0]}, 0, 0, 0);
    for (int w = 0; w <= MP + 1; w++) begin      // R5 R6 R7 quad sweep
      run(1'b0, {2'b00, w[3:0], 1'b0, w[0]}, w, 0, 0);
      run(1'b1, 8'h00, w, 0, 0);                 // R8 erase sweep
    end
    run(1'b0, 8'h14, 1, 1, 0);                   // R7 write refused
    run(1'b0, 8'h00, 2, 0, 0);                   // R11 clean run after an error
    run(1'b0, 8'h08, 3, 0, 1);                   // R10 start while busy
    run(1'b1, 8'h00, 2, 0, 1);                   // R10 start while busy

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule